// File: doc/BRIEF.md
# Breakpoint-Driven Progressive Video Timing Generator

This block produces horizontal sync, vertical sync and a gated RGB pixel stream for a progressive-scan display path. It is driven by a pixel clock. A pixel counter runs across each line and a line counter runs across each frame. Software programs the frame geometry, the sync widths and positions, the sync polarities and a small table of breakpoint lines before it releases the generator.

Blanking is not found by comparing the line counter against porch limits. Each breakpoint entry holds a line number and a 4-bit line-type code. The entry the current line has reached sets that line's type, and the type decides whether input pixels reach the output or are forced to zero. A typical setup puts three entries in ascending order: the first active line (vsync width plus vertical back porch) with the active type, the first front-porch line (total lines minus vertical front porch) with the blanking type, and the line equal to the frame total with the blanking type.

A run-enable input acts as a soft reset. While it is low the counters stay at the origin and the outputs stay idle, so software can reload the configuration and then release the generator. Timing restarts from pixel 0 of line 0.

Top module: `vtg_timing_gen`

## Requirements
- R1: While `rstN` is low, `hsOut`, `vsOut` and `vidOut` are all zero. After any clock edge at which `runEn` is low, the counters sit at pixel 0 of line 0, `vidOut` is zero, and each sync output is at its inactive level. After the first edge with `runEn` high again, the outputs show pixel 0 of line 0.
- R2: The pixel counter steps 0, 1, …, `cfgPixTotal`-1 and then wraps to 0. On that wrap the line counter steps by one, and it wraps from `cfgLineTotal`-1 to 0.
- R3: The horizontal sync is active for pixels 0 to `cfgHsWidth`-1 of every line. Pixel 0 is the position that follows the last pixel of the previous line, so the line total is the start point. A width of 0 gives no pulse.
- R4: `cfgVsStart` holds the desired first vsync line plus one, and `cfgVsWidth` holds the desired width in lines plus one. A desired start equal to `cfgLineTotal` means line 0. The vsync window wraps past the end of the frame. A register value of 0 or 1 gives no pulse.
- R5: Breakpoint entry i occupies bits [i*11 +: 11] of `cfgBpLine` and bits [i*4 +: 4] of `cfgBpType`. Entries are programmed in ascending line order. A line uses the type of the highest-index entry whose line number is at or below it. Lines below entry 0 use the type of the last entry.
- R6: Type code 0x0 is an active line. On such a line `vidOut` always equals the input pixel.
- R7: Every nonzero type code, including the blanking code 0x9, forces `vidOut` to zero while `passEn` is low and passes the input pixel while `passEn` is high.
- R8: `syncPol` bit 0 set makes `hsOut` active-high, and clear makes it active-low. Bit 1 does the same for `vsOut`.
- R9: `hsOut`, `vsOut` and `vidOut` each pass through exactly one register. The values seen after a clock edge belong to the pixel position and the `pixIn` sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Generator run enable; low holds the soft reset |
| passEn | input | 1 | Lets video through on lines with a nonzero type code |
| syncPol | input | 2 | Bit 0: hsync active-high; bit 1: vsync active-high |
| cfgPixTotal | input | 12 | Total pixels per line |
| cfgHsWidth | input | 12 | Hsync width in pixels |
| cfgLineTotal | input | 11 | Total lines per frame |
| cfgVsStart | input | 11 | First vsync line plus one |
| cfgVsWidth | input | 11 | Vsync width in lines plus one |
| cfgBpLine | input | 33 | Three breakpoint line numbers, 11 bits each |
| cfgBpType | input | 12 | Three line-type codes, 4 bits each |
| pixIn | input | 30 | Input RGB pixel, 10 bits per channel |
| hsOut | output | 1 | Horizontal sync |
| vsOut | output | 1 | Vertical sync |
| vidOut | output | 30 | Gated RGB pixel |

## Verification
An internal pixel or line counter that is off by one does not stay hidden. At the next line start the hsync pulse moves by a pixel, and at the next breakpoint or vsync boundary a whole line of video appears or disappears one line early or late. So a wrong count shows at the ports within one line, and certainly within one frame. A wrong breakpoint choice or gate decision shows in the very next output cycle, because the input pixels are random and a wrongly passed or blocked pixel cannot match. The bench compares all three outputs on every cycle against a position model, over several small random geometries and the directed wrap, zero-width and soft-reset cases.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int LT_W = 4;
  localparam logic [LT_W-1:0] LT_ACTIVE = 4'h0;

  typedef struct packed {
    logic run;      // generator released
    logic hsAct;    // current pixel inside hsync window
    logic vsAct;    // current line inside vsync window
    logic passVid;  // current line lets video through
  } vtgStrobe_t;

endpackage

// File: rtl/vtg_bp_select.sv
module vtg_bp_select #(
  parameter int LW  = 11,
  parameter int NBP = 3,
  parameter int TW  = 4
) (
  input  logic [LW-1:0]     lineCnt,
  input  logic [NBP*LW-1:0] bpLine,
  input  logic [NBP*TW-1:0] bpType,
  output logic [TW-1:0]     lineType
);

  logic [NBP-1:0] reached;

  for (genvar i = 0; i < NBP; i++) begin : g_cmp
    assign reached[i] = lineCnt >= bpLine[i*LW +: LW];
  end

  // Ascending entries: the highest reached one wins; none reached keeps
  // the type of the last entry (the frame-end breakpoint).
  always_comb begin
    lineType = bpType[(NBP-1)*TW +: TW];
    for (int i = 0; i < NBP; i++) begin
      if (reached[i]) lineType = bpType[i*TW +: TW];
    end
  end

endmodule

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int PW  = 12,
  parameter int LW  = 11,
  parameter int NBP = 3
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 runEn,
  input  logic                 passEn,
  input  logic [PW-1:0]        pixTotal,
  input  logic [PW-1:0]        hsWidth,
  input  logic [LW-1:0]        lineTotal,
  input  logic [LW-1:0]        vsStartP1,
  input  logic [LW-1:0]        vsWidthP1,
  input  logic [NBP*LW-1:0]    bpLine,
  input  logic [NBP*LT_W-1:0]  bpType,
  output vtgStrobe_t           strb
);

  logic [PW-1:0]   pixCnt;
  logic [LW-1:0]   lineCnt;
  logic            pixLast;
  logic            lineLast;
  logic [LT_W-1:0] lineType;

  assign pixLast  = pixCnt  >= (pixTotal  - PW'(1));
  assign lineLast = lineCnt >= (lineTotal - LW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixCnt  <= '0;
      lineCnt <= '0;
    end else if (!runEn) begin
      pixCnt  <= '0;
      lineCnt <= '0;
    end else if (pixLast) begin
      pixCnt  <= '0;
      lineCnt <= lineLast ? '0 : lineCnt + LW'(1);
    end else begin
      pixCnt  <= pixCnt + PW'(1);
    end
  end

  vtg_bp_select #(.LW(LW), .NBP(NBP), .TW(LT_W)) u_bpSel (
    .lineCnt  (lineCnt),
    .bpLine   (bpLine),
    .bpType   (bpType),
    .lineType (lineType)
  );

  // Vertical sync window, registers hold (value + 1).
  logic [LW:0]   vsStartRaw;
  logic [LW:0]   vsStartLine;
  logic [LW:0]   vsOffset;
  logic [LW-1:0] vsLen;

  always_comb begin
    vsStartRaw  = (vsStartP1 == '0) ? '0 : {1'b0, vsStartP1} - (LW+1)'(1);
    vsStartLine = (vsStartRaw >= {1'b0, lineTotal}) ? vsStartRaw - {1'b0, lineTotal}
                                                    : vsStartRaw;
    if ({1'b0, lineCnt} >= vsStartLine)
      vsOffset = {1'b0, lineCnt} - vsStartLine;
    else
      vsOffset = {1'b0, lineCnt} + {1'b0, lineTotal} - vsStartLine;
    vsLen = (vsWidthP1 == '0) ? '0 : vsWidthP1 - LW'(1);
  end

  always_comb begin
    strb.run     = runEn;
    strb.hsAct   = pixCnt < hsWidth;
    strb.vsAct   = vsOffset < {1'b0, vsLen};
    strb.passVid = (lineType == LT_ACTIVE) || passEn;
  end

  a_r1_hold_origin: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (pixCnt == '0) && (lineCnt == '0));

  a_r2_pix_wrap: assert property (@(posedge clk) disable iff (!rstN)
    runEn && (pixCnt == pixTotal - PW'(1)) |=> pixCnt == '0);

  a_r2_line_step: assert property (@(posedge clk) disable iff (!rstN)
    runEn && (pixCnt == pixTotal - PW'(1)) && (lineCnt < lineTotal - LW'(1))
      |=> lineCnt == $past(lineCnt) + LW'(1));

  a_r2_line_hold: assert property (@(posedge clk) disable iff (!rstN)
    runEn && (pixCnt != pixTotal - PW'(1)) && (pixCnt < pixTotal) |=> $stable(lineCnt));

  a_r3_hs_at_origin: assert property (@(posedge clk) disable iff (!rstN)
    runEn && (pixCnt == '0) && (hsWidth != '0) |-> strb.hsAct);

endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int DW = 30
) (
  input  logic          clk,
  input  logic          rstN,
  input  vtgStrobe_t    strb,
  input  logic [1:0]    syncPol,
  input  logic [DW-1:0] pixIn,
  output logic          hsOut,
  output logic          vsOut,
  output logic [DW-1:0] vidOut
);

  // One register stage on every output keeps sync and video aligned.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hsOut  <= 1'b0;
      vsOut  <= 1'b0;
      vidOut <= '0;
    end else begin
      hsOut  <= (strb.run & strb.hsAct) ^ ~syncPol[0];
      vsOut  <= (strb.run & strb.vsAct) ^ ~syncPol[1];
      vidOut <= (strb.run && strb.passVid) ? pixIn : '0;
    end
  end

  a_r7_blocked_zero: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.run && strb.passVid) |=> vidOut == '0);

  a_r9_video_aligned: assert property (@(posedge clk) disable iff (!rstN)
    strb.run && strb.passVid |=> vidOut == $past(pixIn));

  a_r1_hs_idle: assert property (@(posedge clk) disable iff (!rstN)
    !strb.run |=> hsOut == ~$past(syncPol[0]));

  a_r8_vs_level: assert property (@(posedge clk) disable iff (!rstN)
    strb.run && strb.vsAct |=> vsOut == $past(syncPol[1]));

endmodule

// File: rtl/vtg_timing_gen.sv
module vtg_timing_gen
  import vtg_pkg::*;
#(
  parameter int PW  = 12,
  parameter int LW  = 11,
  parameter int NBP = 3,
  parameter int CW  = 10,
  localparam int DW = 3 * CW
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                runEn,
  input  logic                passEn,
  input  logic [1:0]          syncPol,
  input  logic [PW-1:0]       cfgPixTotal,
  input  logic [PW-1:0]       cfgHsWidth,
  input  logic [LW-1:0]       cfgLineTotal,
  input  logic [LW-1:0]       cfgVsStart,
  input  logic [LW-1:0]       cfgVsWidth,
  input  logic [NBP*LW-1:0]   cfgBpLine,
  input  logic [NBP*LT_W-1:0] cfgBpType,
  input  logic [DW-1:0]       pixIn,
  output logic                hsOut,
  output logic                vsOut,
  output logic [DW-1:0]       vidOut
);

  vtgStrobe_t strb;

  vtg_ctrl #(.PW(PW), .LW(LW), .NBP(NBP)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .passEn    (passEn),
    .pixTotal  (cfgPixTotal),
    .hsWidth   (cfgHsWidth),
    .lineTotal (cfgLineTotal),
    .vsStartP1 (cfgVsStart),
    .vsWidthP1 (cfgVsWidth),
    .bpLine    (cfgBpLine),
    .bpType    (cfgBpType),
    .strb      (strb)
  );

  vtg_datapath #(.DW(DW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .syncPol (syncPol),
    .pixIn   (pixIn),
    .hsOut   (hsOut),
    .vsOut   (vsOut),
    .vidOut  (vidOut)
  );

endmodule

// File: tb/vtg_timing_gen_bench.sv
module vtg_timing_gen_bench;
  localparam int PW = 12, LW = 11, NBP = 3, CW = 10, DW = 3 * CW, TW = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                rstN, runEn, passEn;
  logic [1:0]          syncPol;
  logic [PW-1:0]       cfgPixTotal, cfgHsWidth;
  logic [LW-1:0]       cfgLineTotal, cfgVsStart, cfgVsWidth;
  logic [NBP*LW-1:0]   cfgBpLine;
  logic [NBP*TW-1:0]   cfgBpType;
  logic [DW-1:0]       pixIn;
  logic                hsOut, vsOut;
  logic [DW-1:0]       vidOut;

  vtg_timing_gen u_vtg_timing_gen (
    .clk(clk), .rstN(rstN), .runEn(runEn), .passEn(passEn), .syncPol(syncPol),
    .cfgPixTotal(cfgPixTotal), .cfgHsWidth(cfgHsWidth), .cfgLineTotal(cfgLineTotal),
    .cfgVsStart(cfgVsStart), .cfgVsWidth(cfgVsWidth), .cfgBpLine(cfgBpLine),
    .cfgBpType(cfgBpType), .pixIn(pixIn), .hsOut(hsOut), .vsOut(vsOut), .vidOut(vidOut)
  );

  int checks = 0, errors = 0;
  bit finished = 0;
  int mPix = 0, mLine = 0;
  int pixT, lineT, hsW, vsS, vsW;
  int bpL[NBP];
  int bpT[NBP];

  // R5: highest reached entry in ascending order; none reached -> last entry.
  function automatic int typeOf(int l);
    int t = bpT[NBP-1];
    for (int i = 0; i < NBP; i++) if (l >= bpL[i]) t = bpT[i];
    return t;
  endfunction

  // R4: registers hold value plus one; start equal to total means line 0.
  function automatic bit vsInWindow(int l);
    int d = (vsS == 0) ? 0 : vsS - 1;
    int w = (vsW == 0) ? 0 : vsW - 1;
    int off;
    if (d >= lineT) d -= lineT;
    off = (l >= d) ? l - d : l + lineT - d;
    return off < w;
  endfunction

  task automatic check(string tag, logic [DW-1:0] got, logic [DW-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h (pix %0d line %0d)", tag, got, exp, mPix, mLine);
    end
  endtask

  task automatic setCfg(int pt, int lt, int hw, int vs, int vw,
                        int b0, int b1, int b2, int t0, int t1, int t2,
                        logic [1:0] pol, logic pe);
    pixT = pt; lineT = lt; hsW = hw; vsS = vs; vsW = vw;
    bpL[0] = b0; bpL[1] = b1; bpL[2] = b2;
    bpT[0] = t0; bpT[1] = t1; bpT[2] = t2;
    cfgPixTotal  = PW'(pt);
    cfgLineTotal = LW'(lt);
    cfgHsWidth   = PW'(hw);
    cfgVsStart   = LW'(vs);
    cfgVsWidth   = LW'(vw);
    cfgBpLine    = {LW'(b2), LW'(b1), LW'(b0)};
    cfgBpType    = {TW'(t2), TW'(t1), TW'(t0)};
    syncPol      = pol;
    passEn       = pe;
  endtask

  // One pixel clock: drive at negedge, predict, sample at next negedge.
  task automatic cycle();
    logic eh, ev;
    logic [DW-1:0] ed;
    string vt;
    pixIn = DW'($urandom);
    if (!runEn) begin
      eh = ~syncPol[0]; ev = ~syncPol[1]; ed = '0; vt = "R1 idle video";
      mPix = 0; mLine = 0;
    end else begin
      eh = (mPix < hsW) ^ ~syncPol[0];
      ev = vsInWindow(mLine) ^ ~syncPol[1];
      if (typeOf(mLine) == 0) begin
        ed = pixIn; vt = "R2 R5 R6 R9 active line";
      end else if (passEn) begin
        ed = pixIn; vt = "R5 R7 R9 pass-through line";
      end else begin
        ed = '0; vt = "R5 R7 blanked line";
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(runEn ? "R3 R8 R9 hsync" : "R1 hsync idle", DW'(hsOut), DW'(eh));
    check(runEn ? "R4 R8 R9 vsync" : "R1 vsync idle", DW'(vsOut), DW'(ev));
    check(vt, vidOut, ed);
    if (runEn) begin
      if (mPix >= pixT - 1) begin
        mPix = 0;
        mLine = (mLine >= lineT - 1) ? 0 : mLine + 1;
      end else mPix++;
    end
  endtask

  task automatic runFor(int n);
    for (int i = 0; i < n; i++) cycle();
  endtask

  task automatic startRun(int n);
    runEn = 1'b0;
    cycle();
    runEn = 1'b1;
    runFor(n);
  endtask

  function automatic int pickType();
    int r = $urandom % 3;
    if (r == 0) return 0;
    if (r == 1) return 9;
    return $urandom % 16;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; runEn = 1'b0; pixIn = '0;
    setCfg(16, 10, 3, 11, 3, 2, 8, 10, 0, 9, 9, 2'b11, 1'b0);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R1 reset hsync", DW'(hsOut), '0);
      check("R1 reset vsync", DW'(vsOut), '0);
      check("R1 reset video", vidOut, '0);
    end
    rstN = 1'b1;
    runFor(4);

    // Directed: typical layout, vsync from line 0 for 2 lines, active-high.
    startRun(3 * 16 * 10);

    // Directed: vsync wraps over frame end (lines 9,0,1), active-low, passEn on.
    setCfg(16, 10, 5, 10, 4, 2, 8, 10, 0, 9, 9, 2'b00, 1'b1);
    startRun(2 * 16 * 10 + 7);

    // Directed: soft reset mid-frame, then restart from origin (R1).
    setCfg(12, 8, 2, 4, 2, 1, 6, 8, 0, 9, 9, 2'b01, 1'b0);
    startRun(57);
    runEn = 1'b0;
    runFor(5);
    runEn = 1'b1;
    runFor(2 * 12 * 8);

    // Directed: first entry at line 0, widest hsync, vsync width register 1 (no pulse).
    setCfg(10, 7, 9, 1, 1, 0, 4, 7, 0, 9, 5, 2'b10, 1'b0);
    startRun(2 * 10 * 7);

    // Directed: lines below first entry take last entry's type, zero hsync width.
    setCfg(9, 8, 0, 3, 2, 3, 5, 6, 9, 0, 0, 2'b11, 1'b0);
    startRun(2 * 9 * 8);

    // Random geometries.
    for (int k = 0; k < 10; k++) begin
      int pt = 8 + $urandom % 17;
      int lt = 6 + $urandom % 9;
      int b0 = $urandom % 3;
      int b1 = b0 + 1 + $urandom % (lt - b0 - 1);
      setCfg(pt, lt, $urandom % pt, 1 + $urandom % (lt + 1), $urandom % 5,
             b0, b1, lt, pickType(), pickType(), pickType(),
             2'($urandom), 1'($urandom));
      startRun(pt * lt + $urandom % (pt * lt));
      passEn = ~passEn;
      runFor(pt * lt);
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule